// File: doc/BRIEF.md
# Windowed Frame-Buffer Address Generator

This block turns a stream of pixel strobes into linear frame-memory write addresses. The host marks out a rectangle on the panel (first and last column, first and last row) and sets the memory line length, measured in pixels. It also sets an 18-bit base address and then arms the stream. From then on, every pixel strobe returns one memory address with a write enable. The block walks the rectangle left to right and top to bottom, so the host sends only pixel data and never any addresses.

Configuration arrives through a byte-wide register write port. Wide fields are split into a high byte and a low byte. Each address is computed as `base + row * line_length + column`, modulo 2^18. The base is copied from the start-address registers only when the stream is armed. When the host writes a window register, or arms the stream, the walk goes back to the window's top-left corner.

Top module: `fb_win_addr_gen`

## Requirements
- R1: Reset sets the first column to 0, the last column to 0x13F, the first row to 0, the last row to 0xEF, the line length to 0x140 and the base to 0. While reset is held, `mem_we` is 0 and `mem_addr` is 0. With these defaults, successive pixels after reset get addresses 0, 1, 2, and so on.
- R2: A `pix_valid` sampled high at a clock edge makes `mem_we` high for exactly the following cycle, and `mem_addr` holds that pixel's address in the same cycle. With `pix_valid` low, `mem_we` is low one cycle later.
- R3: Inside a row, each pixel moves the column one to the right, so its address is one more than the previous address.
- R4: The pixel after the one at the last column goes to the first column of the next row. Its address is `base + (row+1)*line_length + first_column`.
- R5: The pixel after the one at the last column of the last row goes back to the first column and first row.
- R6: The line length is a 10-bit field: register 0x08 bits 1:0 are the high part and register 0x09 is the low byte. Every address uses the line length that was programmed.
- R7: The base address is split over three registers: 0x0A bits 1:0 give bits 17:16, 0x0B gives bits 15:8 and 0x0C gives bits 7:0. A one-cycle pulse on `stream_arm` copies these registers into the active base and returns the walk to the window origin. Writing the start registers without arming changes neither the address nor the position of the next pixel.
- R8: The window registers are the first column (0x00 high, 0x01 low), the last column (0x02 high, 0x03 low), the first row (0x04 high, 0x05 low) and the last row (0x06 high, 0x07 low). Each high register keeps bits 1:0. Writing any of these eight registers sends the walk back to the window origin. The pixel strobed in the second cycle after that write is the first to use the origin.
- R9: A write to an unmapped register address, for example 0x0D, changes no address and does not move the walk.
- R10: Addresses wrap modulo 2^18. A base near the top of memory plus the window offset folds back to low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 8 | Register write byte |
| stream_arm | input | 1 | Copy the start address into the base and return the walk to the origin |
| pix_valid | input | 1 | One pixel to place |
| mem_we | output | 1 | Frame-memory write enable |
| mem_addr | output | 18 | Frame-memory write address |

## Verification
The bench first streams a full default row and steps into the second one. This catches an off-by-one at the last column, or a wrong default line length, because either would move address 320. A short vector table then walks a small window with a line length of 10. It crosses a row boundary and a frame boundary, where a design that skips the frame wrap would run into row 3. Directed tests write the start registers without arming, where a design with a live base would jump at once. They rewrite a window register mid-row, where a missed reload would keep counting, and write an unmapped offset, where a sloppy decode would reset or corrupt the walk. A final test puts the base close to 2^18 and checks that the address folds to 0x00006 rather than saturating.

// File: rtl/fbwag_pkg.sv
package fbwag_pkg;
   // register offsets; the host decodes these, so they stay fixed
   localparam logic [7:0] RA_XS_HI     = 8'h00;
   localparam logic [7:0] RA_XS_LO     = 8'h01;
   localparam logic [7:0] RA_XE_HI     = 8'h02;
   localparam logic [7:0] RA_XE_LO     = 8'h03;
   localparam logic [7:0] RA_YS_HI     = 8'h04;
   localparam logic [7:0] RA_YS_LO     = 8'h05;
   localparam logic [7:0] RA_YE_HI     = 8'h06;
   localparam logic [7:0] RA_YE_LO     = 8'h07;
   localparam logic [7:0] RA_STRIDE_HI = 8'h08;
   localparam logic [7:0] RA_STRIDE_LO = 8'h09;
   localparam logic [7:0] RA_BASE_TOP  = 8'h0A;
   localparam logic [7:0] RA_BASE_MID  = 8'h0B;
   localparam logic [7:0] RA_BASE_LO   = 8'h0C;

   function automatic logic is_window_reg(input logic [7:0] a);
      return a <= RA_YE_LO;
   endfunction
endpackage

// File: rtl/fbwag_regs.sv
module fbwag_regs
   import fbwag_pkg::*;
#(
   parameter int COORD_W    = 10,
   parameter int STRIDE_W   = 10,
   parameter int ADDR_W     = 18,
   parameter int DEF_XE     = 'h13F,
   parameter int DEF_YE     = 'hEF,
   parameter int DEF_STRIDE = 'h140
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [7:0]          cfg_addr,
   input  logic [7:0]          cfg_wdata,
   output logic [COORD_W-1:0]  xs,
   output logic [COORD_W-1:0]  xe,
   output logic [COORD_W-1:0]  ys,
   output logic [COORD_W-1:0]  ye,
   output logic [STRIDE_W-1:0] stride,
   output logic [ADDR_W-1:0]   start,
   output logic                win_touch_q
);
   localparam int HI_C = COORD_W - 8;
   localparam int HI_S = STRIDE_W - 8;
   localparam int HI_A = ADDR_W - 16;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xs          <= '0;
         xe          <= COORD_W'(DEF_XE);
         ys          <= '0;
         ye          <= COORD_W'(DEF_YE);
         stride      <= STRIDE_W'(DEF_STRIDE);
         start       <= '0;
         win_touch_q <= 1'b0;
      end else begin
         win_touch_q <= cfg_we && is_window_reg(cfg_addr);
         if (cfg_we) begin
            case (cfg_addr)
               RA_XS_HI:     xs[COORD_W-1:8]  <= cfg_wdata[HI_C-1:0];
               RA_XS_LO:     xs[7:0]          <= cfg_wdata;
               RA_XE_HI:     xe[COORD_W-1:8]  <= cfg_wdata[HI_C-1:0];
               RA_XE_LO:     xe[7:0]          <= cfg_wdata;
               RA_YS_HI:     ys[COORD_W-1:8]  <= cfg_wdata[HI_C-1:0];
               RA_YS_LO:     ys[7:0]          <= cfg_wdata;
               RA_YE_HI:     ye[COORD_W-1:8]  <= cfg_wdata[HI_C-1:0];
               RA_YE_LO:     ye[7:0]          <= cfg_wdata;
               RA_STRIDE_HI: stride[STRIDE_W-1:8] <= cfg_wdata[HI_S-1:0];
               RA_STRIDE_LO: stride[7:0]      <= cfg_wdata;
               RA_BASE_TOP:  start[ADDR_W-1:16] <= cfg_wdata[HI_A-1:0];
               RA_BASE_MID:  start[15:8]      <= cfg_wdata;
               RA_BASE_LO:   start[7:0]       <= cfg_wdata;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/fbwag_walker.sv
module fbwag_walker #(
   parameter int COORD_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reload,
   input  logic               step,
   input  logic [COORD_W-1:0] xs,
   input  logic [COORD_W-1:0] xe,
   input  logic [COORD_W-1:0] ys,
   input  logic [COORD_W-1:0] ye,
   output logic [COORD_W-1:0] x,
   output logic [COORD_W-1:0] y
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x <= '0;
         y <= '0;
      end else if (reload) begin
         x <= xs;
         y <= ys;
      end else if (step) begin
         if (x == xe) begin
            x <= xs;
            y <= (y == ye) ? ys : y + COORD_W'(1);
         end else begin
            x <= x + COORD_W'(1);
         end
      end
   end
endmodule

// File: rtl/fbwag_lin.sv
module fbwag_lin #(
   parameter int COORD_W   = 10,
   parameter int STRIDE_W  = 10,
   parameter int ADDR_W    = 18,
   parameter int ADDR_PIPE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm,
   input  logic [ADDR_W-1:0]   start,
   input  logic                pix_valid,
   input  logic [COORD_W-1:0]  x,
   input  logic [COORD_W-1:0]  y,
   input  logic [STRIDE_W-1:0] stride,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr
);
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offset;

   always_ff @(posedge clk) begin
      if (!rst_n)   base <= '0;
      else if (arm) base <= start;
   end

   always_comb offset = ADDR_W'(y) * ADDR_W'(stride) + ADDR_W'(x);

   if (ADDR_PIPE == 0) begin : g_direct
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
         end else begin
            mem_we <= pix_valid;
            if (pix_valid) mem_addr <= base + offset;
         end
      end
   end else begin : g_piped
      logic              v1;
      logic [ADDR_W-1:0] off_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v1       <= 1'b0;
            off_q    <= '0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
         end else begin
            v1     <= pix_valid;
            mem_we <= v1;
            if (pix_valid) off_q <= offset;
            if (v1) mem_addr <= base + off_q;
         end
      end
   end
endmodule

// File: rtl/fb_win_addr_gen.sv
module fb_win_addr_gen #(
   parameter int COORD_W    = 10,
   parameter int STRIDE_W   = 10,
   parameter int ADDR_W     = 18,
   parameter int ADDR_PIPE  = 0,
   parameter int DEF_XE     = 'h13F,
   parameter int DEF_YE     = 'hEF,
   parameter int DEF_STRIDE = 'h140
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic              stream_arm,
   input  logic              pix_valid,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr
);
   if (COORD_W < 9 || COORD_W > 16) begin : g_bad_coord
      $error("COORD_W must lie in 9..16");
   end
   if (STRIDE_W < 9 || STRIDE_W > 16) begin : g_bad_stride
      $error("STRIDE_W must lie in 9..16");
   end
   if (ADDR_W < 17 || ADDR_W > 24) begin : g_bad_addr
      $error("ADDR_W must lie in 17..24");
   end
   if (ADDR_PIPE != 0 && ADDR_PIPE != 1) begin : g_bad_pipe
      $error("ADDR_PIPE must be 0 or 1");
   end

   logic [COORD_W-1:0]  win_xs, win_xe, win_ys, win_ye;
   logic [COORD_W-1:0]  cur_x, cur_y;
   logic [STRIDE_W-1:0] line_len;
   logic [ADDR_W-1:0]   start_addr;
   logic                win_touch_q;
   logic                reload;

   assign reload = stream_arm | win_touch_q;

   fbwag_regs #(
      .COORD_W(COORD_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W),
      .DEF_XE(DEF_XE), .DEF_YE(DEF_YE), .DEF_STRIDE(DEF_STRIDE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .xs(win_xs), .xe(win_xe), .ys(win_ys),
      .ye(win_ye), .stride(line_len), .start(start_addr),
      .win_touch_q(win_touch_q)
   );

   fbwag_walker #(.COORD_W(COORD_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .reload(reload), .step(pix_valid),
      .xs(win_xs), .xe(win_xe), .ys(win_ys), .ye(win_ye),
      .x(cur_x), .y(cur_y)
   );

   fbwag_lin #(
      .COORD_W(COORD_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W),
      .ADDR_PIPE(ADDR_PIPE)
   ) u_lin (
      .clk(clk), .rst_n(rst_n), .arm(stream_arm), .start(start_addr),
      .pix_valid(pix_valid), .x(cur_x), .y(cur_y), .stride(line_len),
      .mem_we(mem_we), .mem_addr(mem_addr)
   );
endmodule

// File: rtl/fbwag_chk.sv
module fbwag_chk #(
   parameter int COORD_W   = 10,
   parameter int ADDR_PIPE = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pix_valid,
   input logic               reload,
   input logic               mem_we,
   input logic [COORD_W-1:0] x,
   input logic [COORD_W-1:0] y,
   input logic [COORD_W-1:0] xs,
   input logic [COORD_W-1:0] xe,
   input logic [COORD_W-1:0] ys,
   input logic [COORD_W-1:0] ye
);
   if (ADDR_PIPE == 0) begin : g_lat1
      p_we_follows_pix_r2: assert property (@(posedge clk) disable iff (!rst_n)
         pix_valid |=> mem_we);
      p_we_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !pix_valid |=> !mem_we);
   end else begin : g_lat2
      p_we_follows_pix_r2: assert property (@(posedge clk) disable iff (!rst_n)
         pix_valid |=> ##1 mem_we);
      p_we_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !pix_valid |=> ##1 !mem_we);
   end

   p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !reload && x != xe) |=> (x == $past(x) + COORD_W'(1)) && $stable(y));

   p_row_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !reload && x == xe && y != ye) |=>
         (x == $past(xs)) && (y == $past(y) + COORD_W'(1)));

   p_frame_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !reload && x == xe && y == ye) |=>
         (x == $past(xs)) && (y == $past(ys)));

   p_origin_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (x == $past(xs)) && (y == $past(ys)));

   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_valid && !reload) |=> $stable(x) && $stable(y));
endmodule

bind fb_win_addr_gen fbwag_chk #(.COORD_W(COORD_W), .ADDR_PIPE(ADDR_PIPE)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .reload(reload),
   .mem_we(mem_we), .x(cur_x), .y(cur_y), .xs(win_xs), .xe(win_xe),
   .ys(win_ys), .ye(win_ye)
);

// File: tb/sim_fb_win_addr_gen.sv
module sim_fb_win_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        stream_arm = 1'b0;
   logic        pix_valid = 1'b0;
   logic        mem_we;
   logic [17:0] mem_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fb_win_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .stream_arm(stream_arm), .pix_valid(pix_valid),
      .mem_we(mem_we), .mem_addr(mem_addr)
   );

   // window origin (2,1), last (4,2), line length 10, base 0x100
   localparam logic [17:0] VEC [0:7] = '{
      18'h10C, 18'h10D, 18'h10E,   // row 1, R3
      18'h116, 18'h117, 18'h118,   // row 2 after row step, R4 / R6
      18'h10C, 18'h10D             // frame wrap, R5
   };

   task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp);
      end
   endtask

   task automatic pixel(input string req, input logic [17:0] exp);
      pix_valid = 1'b1;
      @(negedge clk);
      pix_valid = 1'b0;
      chk({req, " we"}, {17'd0, mem_we}, 18'd1);
      chk(req, mem_addr, exp);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic arm();
      stream_arm = 1'b1;
      @(negedge clk);
      stream_arm = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset
      chk("R1 reset we", {17'd0, mem_we}, 18'd0);
      chk("R1 reset addr", mem_addr, 18'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: no strobe, no write
      chk("R2 idle we", {17'd0, mem_we}, 18'd0);

      // R1 / R4: default window walks 320 columns then steps to row 1
      for (int i = 0; i < 321; i++) pixel("R1 default walk", 18'(i));
      @(negedge clk);
      chk("R2 we drops", {17'd0, mem_we}, 18'd0);

      // configure window, line length, base
      wr(8'h00, 8'h00); wr(8'h01, 8'h02);
      wr(8'h02, 8'h00); wr(8'h03, 8'h04);
      wr(8'h04, 8'h00); wr(8'h05, 8'h01);
      wr(8'h06, 8'h00); wr(8'h07, 8'h02);
      wr(8'h08, 8'h00); wr(8'h09, 8'h0A);
      wr(8'h0A, 8'h00); wr(8'h0B, 8'h01); wr(8'h0C, 8'h00);
      arm();
      @(negedge clk);
      for (int i = 0; i < 8; i++) pixel("R3/R4/R5/R6 table", VEC[i]);

      // R9: unmapped write leaves the walk alone (next is column 4 row 1)
      wr(8'h0D, 8'hFF);
      @(negedge clk);
      pixel("R9 unmapped", 18'h10E);

      // R7: start registers without arm: old base, no rewind
      wr(8'h0A, 8'h02); wr(8'h0B, 8'h00); wr(8'h0C, 8'h00);
      @(negedge clk);
      pixel("R7 no arm", 18'h116);
      arm();
      pixel("R7 armed", 18'h2000C);
      pixel("R3 armed step", 18'h2000D);

      // R8: rewriting a window register rewinds to origin
      wr(8'h05, 8'h01);
      @(negedge clk);
      pixel("R8 rewind", 18'h2000C);

      // R10: modulo wrap of the address
      wr(8'h0A, 8'h03); wr(8'h0B, 8'hFF); wr(8'h0C, 8'hF0);
      arm();
      pixel("R10 near top", 18'h3FFFC);
      pixel("R10 near top", 18'h3FFFD);
      pixel("R10 near top", 18'h3FFFE);
      pixel("R10 folded", 18'h00006);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule